// File: doc/BRIEF.md
# Flow-Through Burst SRAM Controller

This block is the clocked front end of a synchronous burst static RAM. It holds a behavioural storage array of 256 words by 36 bits, split into four 9-bit byte lanes. Address, chip selects, write controls and write data are all captured on the rising clock edge. A burst begins when either of two address strobes is asserted. The processor-side strobe can only start a read. The cache-side strobe can start a read or a write.

After the first beat, a 2-bit counter supplies the low address bits. It moves forward only on cycles where the advance input is asserted. It counts either linearly with wrap-around or in interleaved (XOR) order, and the order is chosen when the burst starts.

Read data comes straight out of the array, addressed by the registered burst address, within the same cycle (flow-through). A write is committed at the following clock edge. It lands on the byte lanes chosen by the byte-write controls, or on all lanes when the global write is asserted. All control inputs are active-low, and reset is synchronous and active-high.

Top module: `burst_sram_ctl`

## Requirements
- R1: While reset is high and after it, until a burst is started, `rd_valid` is 0 and `rdata` is all zeros.
- R2: A processor strobe (`ads_proc_n` low) while `en0_n` is low starts a read burst. The address captured at that edge becomes the burst base, and its word is presented on `rdata` in the cycle after the edge.
- R3: A cache strobe (`ads_cache_n` low) always starts a burst from `addr`. If both strobes are low and `en0_n` is low, the processor strobe wins and the cycle is a read, with no write whatever the write controls say.
- R4: A processor strobe is ignored while `en0_n` is high. The burst address and the selection state carry on as if the strobe were absent.
- R5: On a cycle with no burst start, `adv_n` low steps the burst counter by one. With `adv_n` high the burst address is held (suspend).
- R6: With `order_sel` = 0 at burst start (linear), beat k addresses `{base[7:2], (base[1:0] + k) mod 4}`.
- R7: With `order_sel` = 1 at burst start (interleaved), beat k addresses `{base[7:2], base[1:0] XOR k}`.
- R8: With `gw_n` high, byte lane i (`wdata` bits 9i+8 down to 9i) is written only when `bwe_n` is low and `bw_n[i]` is low. With `bwe_n` high, nothing is written.
- R9: With `gw_n` low on any cycle other than a processor-strobe start, all four lanes are written, regardless of `bwe_n` and `bw_n`.
- R10: A burst start with any of `en0_n`, `en1_n`, `en2_n` high deselects the device from the next cycle on. While deselected, `rd_valid` is 0, `rdata` is zero, and write cycles change no stored word.
- R11: Write controls and data captured at edge N are committed at edge N+1 to the burst address in force between those edges. During that write cycle `rd_valid` is 0. A read issued at edge N+1 to the same word already returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | External word address, loaded on a burst start |
| en0_n | input | 1 | Chip enable 0, active-low; also gates the processor strobe |
| en1_n | input | 1 | Chip enable 1, active-low |
| en2_n | input | 1 | Chip enable 2, active-low |
| ads_proc_n | input | 1 | Processor-side address strobe, active-low (read start) |
| ads_cache_n | input | 1 | Cache-side address strobe, active-low |
| adv_n | input | 1 | Burst advance, active-low |
| order_sel | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active-low, all lanes |
| bwe_n | input | 1 | Byte-write enable, active-low |
| bw_n | input | 4 | Per-lane byte-write selects, active-low |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Flow-through read data, zero when not valid |
| rd_valid | output | 1 | Output enable: selected and not a write cycle |

## Verification
The array is first filled by global-write bursts. Every one of the four start offsets is then burst-read in linear order and in interleaved order. These eight runs show whether the counter wraps by addition or by XOR, and whether a start offset is handled correctly.

Directed cases cover the rest:
- byte-select patterns with and without the byte-write enable, which separate the per-lane decode from the global override;
- both strobes together, which shows that a simultaneous processor strobe suppresses a write;
- a masked processor strobe in mid-burst;
- a deselect in mid-burst followed by ignored writes;
- a read immediately after a write to the same word, which pins down the commit edge.

Seeded random traffic then mixes all of these against a reference memory model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits for burst beat 'beat' from start offset 'ofs'
  function automatic logic [1:0] burst_low(input logic [1:0] ofs,
                                           input logic [1:0] beat,
                                           input burst_order_e ord);
    if (ord == BURST_INTERLEAVE) return ofs ^ beat;
    else                         return ofs + beat;
  endfunction

endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          adv_i,
  input  burst_order_e  order_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cur_o
);

  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  burst_order_e  ord_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= 2'd0;
      ord_q  <= BURST_LINEAR;
    end else if (start_i) begin
      base_q <= addr_i;
      beat_q <= 2'd0;
      ord_q  <= order_i;
    end else if (adv_i) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign cur_o = {base_q[AW-1:2], burst_low(base_q[1:0], beat_q, ord_q)};

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cur_o == $past(addr_i)));                               // R2
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!start_i && adv_i) |=> (beat_q == $past(beat_q) + 2'd1));           // R5
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !adv_i) |=> $stable(cur_o));                            // R5

endmodule

// File: rtl/sbs_bw_decode.sv
module sbs_bw_decode #(
  parameter int NB = 4
) (
  input  logic          gw_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] bw_n_i,
  input  logic          read_only_i,
  output logic [NB-1:0] lanes_o
);

  always_comb begin
    if (read_only_i)   lanes_o = '0;
    else if (!gw_n_i)  lanes_o = '1;
    else if (!bwe_n_i) lanes_o = ~bw_n_i;
    else               lanes_o = '0;
  end

endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic [NB-1:0]    we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*LW-1:0] wdata_i,
  output logic [NB*LW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LW +: LW];
    end

    assign rdata_o[g*LW +: LW] = mem[addr_i];
  end

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import sbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             en0_n,
  input  logic             en1_n,
  input  logic             en2_n,
  input  logic             ads_proc_n,
  input  logic             ads_cache_n,
  input  logic             adv_n,
  input  logic             order_sel,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NB-1:0]    bw_n,
  input  logic [NB*LW-1:0] wdata,
  output logic [NB*LW-1:0] rdata,
  output logic             rd_valid
);

  localparam int DW = NB * LW;

  logic          all_en, proc_go, cache_go, start, adv;
  logic          sel_q;
  logic [NB-1:0] lanes_d, lanes_q, we;
  logic [DW-1:0] wdata_q, ram_rd;
  logic [AW-1:0] cur_addr;

  assign all_en   = !en0_n && !en1_n && !en2_n;
  assign proc_go  = !ads_proc_n && !en0_n;
  assign cache_go = !ads_cache_n && !proc_go;
  assign start    = proc_go || cache_go;
  assign adv      = !start && !adv_n;

  sbs_burst_ctr #(.AW(AW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .adv_i   (adv),
    .order_i (burst_order_e'(order_sel)),
    .addr_i  (addr),
    .cur_o   (cur_addr)
  );

  sbs_bw_decode #(.NB(NB)) u_dec (
    .gw_n_i      (gw_n),
    .bwe_n_i     (bwe_n),
    .bw_n_i      (bw_n),
    .read_only_i (proc_go),
    .lanes_o     (lanes_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      lanes_q <= '0;
      wdata_q <= '0;
    end else begin
      if (start) sel_q <= all_en;
      lanes_q <= lanes_d;
      wdata_q <= wdata;
    end
  end

  assign we = sel_q ? lanes_q : '0;

  sbs_lane_ram #(.AW(AW), .NB(NB), .LW(LW)) u_ram (
    .clk     (clk),
    .we_i    (we),
    .addr_i  (cur_addr),
    .wdata_i (wdata_q),
    .rdata_o (ram_rd)
  );

  assign rd_valid = sel_q && (lanes_q == '0);
  assign rdata    = rd_valid ? ram_rd : '0;

  AST_DESEL_NEXT: assert property (@(posedge clk) disable iff (rst)
    (start && !all_en) |=> !rd_valid);                                   // R10
  AST_PROC_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && en0_n && ads_cache_n && adv_n) |=> $stable(cur_addr)); // R4
  AST_BOTH_READ: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && !en0_n && !ads_cache_n) |=> (we == '0));             // R3
  AST_GW_ALL: assert property (@(posedge clk) disable iff (rst)
    (!gw_n && !proc_go) |=> (&lanes_q));                                 // R9
  AST_NO_BWE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (gw_n && bwe_n) |=> (lanes_q == '0));                                // R8
  AST_LANE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    gw_n |=> ((lanes_q & $past(bw_n)) == '0));                           // R8

endmodule

// File: tb/burst_sram_ctl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        en0_n = 1'b0, en1_n = 1'b0, en2_n = 1'b0;
  logic        ads_proc_n = 1'b1, ads_cache_n = 1'b1, adv_n = 1'b1;
  logic        order_sel = 1'b0, gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [35:0] mm [256];
  logic [7:0]  m_base = '0;
  logic [1:0]  m_beat = '0;
  logic        m_ord = 1'b0, m_sel = 1'b0;
  logic [3:0]  m_lanes = '0;
  logic [35:0] m_wd = '0;

  always #2.5 clk = ~clk;

  burst_sram_ctl u_burst_sram_ctl (
    .clk(clk), .rst(rst), .addr(addr), .en0_n(en0_n), .en1_n(en1_n), .en2_n(en2_n),
    .ads_proc_n(ads_proc_n), .ads_cache_n(ads_cache_n), .adv_n(adv_n),
    .order_sel(order_sel), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] exp_addr(input logic [7:0] b, input logic [1:0] k,
                                          input logic o);
    logic [1:0] lo;
    lo = o ? (b[1:0] ^ k) : (b[1:0] + k);   // R6 linear, R7 interleaved
    return {b[7:2], lo};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic model_edge();
    logic [7:0] cur;
    logic pgo, cgo;
    cur = exp_addr(m_base, m_beat, m_ord);
    if (m_sel)
      for (int i = 0; i < 4; i++)
        if (m_lanes[i]) mm[cur][i*9 +: 9] = m_wd[i*9 +: 9];
    pgo = !ads_proc_n && !en0_n;
    cgo = !ads_cache_n && !pgo;
    if (pgo || cgo) begin
      m_base = addr; m_beat = 2'd0; m_ord = order_sel;
      m_sel  = !en0_n && !en1_n && !en2_n;
    end else if (!adv_n) m_beat = m_beat + 2'd1;
    if (pgo)         m_lanes = 4'h0;
    else if (!gw_n)  m_lanes = 4'hF;
    else if (!bwe_n) m_lanes = ~bw_n;
    else             m_lanes = 4'h0;
    m_wd = wdata;
  endtask

  task automatic check(input string tag);
    logic        ev;
    logic [35:0] ed;
    ev = m_sel && (m_lanes == 4'h0);
    ed = ev ? mm[exp_addr(m_base, m_beat, m_ord)] : '0;
    checks++;
    if (rd_valid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: rd_valid/rdata got %0b/%h expected %0b/%h",
               tag, rd_valid, rdata, ev, ed);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk); #1; model_edge();
    @(negedge clk); check(tag);
  endtask

  task automatic idle();
    ads_proc_n = 1'b1; ads_cache_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
    en0_n = 1'b0; en1_n = 1'b0; en2_n = 1'b0;
  endtask

  task automatic proc_read(input logic [7:0] a, input logic o, input string tag);
    idle(); ads_proc_n = 1'b0; addr = a; order_sel = o; cyc(tag);
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 1'b0; cyc(tag); end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); check("R1");
    rst = 1'b0;
    @(negedge clk); check("R1");

    // R9: fill memory with global-write bursts
    for (int b = 0; b < 64; b++) begin
      idle(); ads_cache_n = 1'b0; addr = 8'(b * 4); order_sel = 1'b0;
      gw_n = 1'b0; bwe_n = 1'b1; wdata = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      cyc("R9");
      for (int k = 0; k < 3; k++) begin
        idle(); adv_n = 1'b0; gw_n = 1'b0;
        wdata = {$urandom, $urandom} & 36'hF_FFFF_FFFF; cyc("R9");
      end
    end
    idle(); cyc("R2");

    // R6 / R7: every start offset in both orders
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++) proc_read(8'h40 + 8'(s), o[0], o ? "R7" : "R6");
    cyc("R5"); cyc("R5");                      // suspend holds address

    // R3: cache-strobe read, then both strobes with write controls
    idle(); ads_cache_n = 1'b0; addr = 8'h82; order_sel = 1'b1; cyc("R3");
    idle(); adv_n = 1'b0; cyc("R3");
    idle(); ads_proc_n = 1'b0; ads_cache_n = 1'b0; addr = 8'h90; gw_n = 1'b0;
    wdata = 36'h123456789; cyc("R3");
    idle(); cyc("R3");

    // R4: masked processor strobe mid-burst
    proc_read(8'h20, 1'b0, "R2");
    idle(); ads_proc_n = 1'b0; ads_cache_n = 1'b1; addr = 8'h20; cyc("R4");
    idle(); adv_n = 1'b0; cyc("R4");
    idle(); ads_proc_n = 1'b0; en0_n = 1'b1; addr = 8'hF0; cyc("R4");
    idle(); adv_n = 1'b0; cyc("R4");

    // R8: partial byte writes, then reads
    idle(); ads_cache_n = 1'b0; addr = 8'h30; bwe_n = 1'b0; bw_n = 4'b1010;
    wdata = 36'hABCDEF012; cyc("R8");
    idle(); adv_n = 1'b0; bwe_n = 1'b1; bw_n = 4'b0000; wdata = 36'h0; cyc("R8");
    idle(); adv_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b0111; wdata = 36'hFFFFFFFFF; cyc("R8");
    proc_read(8'h30, 1'b0, "R8");
    // R9: global write ignores byte selects
    idle(); ads_cache_n = 1'b0; addr = 8'h34; gw_n = 1'b0; bwe_n = 1'b1; bw_n = 4'hF;
    wdata = 36'h5A5A5A5A5; cyc("R9");
    proc_read(8'h34, 1'b0, "R9");

    // R10: deselect mid-burst, writes ignored
    proc_read(8'h50, 1'b0, "R10");
    idle(); ads_cache_n = 1'b0; en1_n = 1'b1; addr = 8'h50; cyc("R10");
    for (int k = 0; k < 3; k++) begin
      idle(); adv_n = 1'b0; gw_n = 1'b0; wdata = 36'h0F0F0F0F0; cyc("R10");
    end
    idle(); ads_cache_n = 1'b0; en2_n = 1'b1; addr = 8'h51; gw_n = 1'b0; cyc("R10");
    idle(); cyc("R10");
    proc_read(8'h50, 1'b0, "R10");

    // R11: read right after write to the same word
    idle(); ads_cache_n = 1'b0; addr = 8'h60; gw_n = 1'b0; wdata = 36'h987654321; cyc("R11");
    idle(); ads_proc_n = 1'b0; addr = 8'h60; cyc("R11");
    idle(); ads_cache_n = 1'b0; addr = 8'h61; bwe_n = 1'b0; bw_n = 4'b1110;
    wdata = 36'h000000111; cyc("R11");
    idle(); adv_n = 1'b1; cyc("R11");          // suspended: same word, now readable

    // mixed seeded random traffic
    for (int n = 0; n < 2500; n++) begin
      int r;
      idle();
      r = int'($urandom % 16);
      if (r < 2)      ads_proc_n = 1'b0;
      else if (r < 4) ads_cache_n = 1'b0;
      else if (r < 5) begin ads_proc_n = 1'b0; ads_cache_n = 1'b0; end
      else if (r < 12) adv_n = 1'b0;
      en0_n = ($urandom % 10) == 0;
      en1_n = ($urandom % 14) == 0;
      en2_n = ($urandom % 14) == 0;
      addr = 8'($urandom); order_sel = 1'($urandom);
      gw_n = ($urandom % 5) != 0; bwe_n = 1'($urandom); bw_n = 4'($urandom);
      wdata = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      cyc("R5");
    end
    idle(); cyc("R5");
    summary();
    $finish;
  end

endmodule